// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column addresses of a single SDRAM read or write burst. A memory controller gives it a starting column, a 3-bit length code and an ordering select. It also gives a one-cycle start pulse. From the next clock the block presents one column per cycle, with a valid flag and a flag that marks the final beat.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned block whose size equals the burst length. The column bits above the block field are held for the whole burst. The bits below the field start at the supplied value and advance in either wrapping-increment order or XOR order. A page-length burst counts through the 256-column page, wrapping from 255 to 0, until the terminate input ends it.

A length code the block does not support is refused. A page-length burst that asks for XOR order is also refused. In both cases the block raises a one-cycle error pulse and emits no addresses.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `valid_o`, `last_o` and `err_o` are low.
- R2: A start pulse while idle with an accepted code makes `valid_o` high in the next cycle, and the first `col_o` equals `start_col_i`. Length codes: 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8, 3'b111=page.
- R3: In increment order (`interleave_i`=0) with length L, beat n has low bits (start low bits + n) mod L.
- R4: In XOR order (`interleave_i`=1) with length L, beat n has low bits equal to the start low bits XOR n.
- R5: During a fixed burst, `col_o` bits 7:1 (L=2), 7:2 (L=4) or 7:3 (L=8) stay equal to those of `start_col_i`.
- R6: A length-1 burst produces exactly one valid beat, equal to the start column, and `last_o` is high on it.
- R7: A fixed burst of length L has exactly L valid beats. `last_o` is high on beat L-1 only, and `valid_o` is low in the cycle after it.
- R8: A page burst in increment order emits (start + n) mod 256 and continues past 255 back to 0. It ignores its count and ends only on `term_i`. `last_o` is high in the cycle `term_i` is high, and that beat is the final one.
- R9: A start pulse while idle with code 3'b100, 3'b101 or 3'b110, or with code 3'b111 and `interleave_i`=1, gives `err_o` high for exactly the next cycle and no valid beat.
- R10: A start pulse while a burst is valid is ignored. The running burst continues unchanged, and no new burst follows it unless a start arrives while idle.
- R11: `term_i` has no effect during a fixed-length burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a new burst |
| start_col_i | input | 8 | Starting column |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 selects XOR order, 0 increment order |
| term_i | input | 1 | Ends a page-length burst on this beat |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | `col_o` carries a beat |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Previous start used an unsupported code |

## Verification
A corrupted block base or mask appears at `col_o` on the very next beat, either as a column outside the aligned block or as a wrong order. The bench compares every beat, so the fault is caught in the same cycle. A wrong beat counter or busy flag moves `last_o` or makes `valid_o` linger or drop early. That is visible at most one beat after the expected final address. A refused code that wrongly starts a burst shows up one cycle after the start, through `valid_o` and a missing `err_o`.

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);

  localparam logic [COL_W-1:0] M1 = '0;
  localparam logic [COL_W-1:0] M2 = COL_W'(1);
  localparam logic [COL_W-1:0] M4 = COL_W'(3);
  localparam logic [COL_W-1:0] M8 = COL_W'(7);
  localparam logic [COL_W-1:0] MP = '1;

  logic             busy_q, il_q, page_q, err_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic [COL_W-1:0] new_mask, offs;
  logic             code_ok;

  always_comb begin
    code_ok  = 1'b1;
    new_mask = M1;
    case (len_code_i)
      3'b000: new_mask = M1;
      3'b001: new_mask = M2;
      3'b010: new_mask = M4;
      3'b011: new_mask = M8;
      3'b111: begin new_mask = MP; code_ok = !interleave_i; end
      default: code_ok = 1'b0;
    endcase
  end

  assign offs    = il_q ? (base_q ^ beat_q) : (base_q + beat_q);
  assign col_o   = (base_q & ~mask_q) | (offs & mask_q);
  assign valid_o = busy_q;
  assign last_o  = busy_q && (page_q ? term_i : (beat_q == mask_q));
  assign err_o   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      il_q   <= 1'b0;
      page_q <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else begin
      err_q <= 1'b0;
      if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        beat_q <= beat_q + 1'b1;
      end else if (start_i) begin
        if (code_ok) begin
          busy_q <= 1'b1;
          base_q <= start_col_i;
          beat_q <= '0;
          mask_q <= new_mask;
          il_q   <= interleave_i;
          page_q <= (len_code_i == 3'b111);
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && start_i && code_ok) |=> (valid_o && col_o == $past(start_col_i)));

  // R5
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> ((col_o & ~mask_q) == $past(col_o & ~mask_q)));

  // R7
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !valid_o);

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R10
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> valid_o);

endmodule

// File: tb/sdram_col_seq_tb.sv
`timescale 1ns/1ps
module sdram_col_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, interleave_i = 1'b0, term_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [7:0] col_o;
  logic       valid_o, last_o, err_o;

  int errors = 0, checks = 0;
  bit done = 0;

  int m_busy = 0, m_base = 0, m_n = 0, m_len = 0, m_il = 0, m_page = 0, m_err = 0;

  always #2.5 clk = ~clk;

  sdram_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_col();
    int lo, blk;
    if (m_page) return (m_base + m_n) % 256;
    blk = m_base - (m_base % m_len);
    lo  = m_base % m_len;
    if (m_il) return blk + (lo ^ m_n);
    return blk + ((lo + m_n) % m_len);
  endfunction

  // drive inputs at a falling edge, compare, advance the model, wait one cycle
  task automatic step(bit s, int c, int code, bit il, bit t);
    int e_last, nl;
    @(negedge clk);
    start_i = s; start_col_i = 8'(c); len_code_i = 3'(code);
    interleave_i = il; term_i = t;
    #1;
    e_last = m_busy && (m_page ? int'(t) : (m_n == m_len - 1));
    check("R1/R7/R9/R10 valid", int'(valid_o), m_busy);
    check("R6/R7/R8/R11 last", int'(last_o), e_last);
    check("R9 err", int'(err_o), m_err);
    if (m_busy) check("R2/R3/R4/R5/R8 col", int'(col_o), exp_col());
    m_err = 0;
    if (m_busy) begin
      if (e_last) m_busy = 0;
      else m_n = (m_n + 1) % 256;
    end else if (s) begin
      case (code)
        0: nl = 1;
        1: nl = 2;
        2: nl = 4;
        3: nl = 8;
        7: nl = il ? 0 : 256;
        default: nl = 0;
      endcase
      if (nl == 0) m_err = 1;
      else begin
        m_busy = 1; m_base = c; m_n = 0; m_len = nl; m_il = il; m_page = (code == 7);
      end
    end
  endtask

  task automatic burst(int c, int code, bit il);
    step(1, c, code, il, 0);
    repeat (10) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(valid_o), 0);
    check("R1 err in reset", int'(err_o), 0);
    check("R1 last in reset", int'(last_o), 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0);
    // R3 R5 increment order with block wrap
    burst(8'h35, 1, 0);
    burst(8'h4E, 2, 0);
    burst(8'h9D, 3, 0);
    burst(8'h00, 3, 0);
    // R4 XOR order
    burst(8'h35, 1, 1);
    burst(8'h4E, 2, 1);
    burst(8'h9D, 3, 1);
    burst(8'hFA, 3, 1);
    // R6 single beat
    burst(8'h7F, 0, 0);
    burst(8'h80, 0, 1);
    // R10 start held during burst with other settings
    step(1, 8'h13, 3, 0, 0);
    repeat (12) step(1, 8'hC2, 2, 1, 0);
    repeat (3) step(0, 0, 0, 0, 0);
    // back-to-back: start in the first idle cycle after a burst
    step(1, 8'h21, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(1, 8'h22, 1, 1, 0);
    repeat (4) step(0, 0, 0, 0, 0);
    // R9 refused codes
    burst(8'h10, 4, 0);
    burst(8'h10, 5, 1);
    burst(8'h10, 6, 0);
    burst(8'h10, 7, 1);
    // R11 terminate during a fixed burst
    step(1, 8'h6B, 3, 0, 1);
    repeat (10) step(0, 0, 0, 0, 1);
    // R8 page burst across the page end
    step(1, 8'hF0, 7, 0, 0);
    repeat (300) step(0, 0, 0, 0, 0);
    step(1, 8'h00, 0, 0, 1);
    repeat (3) step(0, 0, 0, 0, 0);
    // R8 page burst terminated on its first beat
    step(1, 8'h44, 7, 0, 0);
    step(0, 0, 0, 0, 1);
    repeat (3) step(0, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule